// File: doc/BRIEF.md
# Status and Control Flags Unit

This block holds the processor flags word. After an 8-, 16- or 32-bit add or subtract, it receives the two operands, the result the datapath produced, the operation width and whether the operation was a subtract. From these it derives and registers six status flags: carry or borrow, parity, nibble carry, zero, sign and signed overflow. The block does not perform the arithmetic. It only judges the arithmetic that the datapath has already done.

The block also keeps three control bits. The string-step direction bit and the interrupt-enable bit each have their own set and clear commands. The single-step trap bit is loaded from a data input. The interrupt-enable bit gates a maskable interrupt request, so the request is accepted only while that bit is 1. All state is registered, and a change shows on `flags_o` in the cycle after the clock edge that captures it.

Top module: `flags_unit`

## Requirements
- R1: After an asynchronous reset (rst_ni low), flags_o reads 16'h0002 and irq_take_o is 0.
- R2: When upd_en_i is 1, bit 0 (carry) is loaded with the following value at the top bit of the selected width. On an add (sub_i=0) it is the carry out of that bit. On a subtract (sub_i=1, res = opa - opb) it is the borrow.
- R3: On an update, bit 2 (parity) becomes 1 when res_i[7:0] holds an even number of ones, at every width.
- R4: On an update, bit 4 (nibble carry) becomes the carry or borrow from bit 3 into bit 4, which is opa_i[4]^opb_i[4]^res_i[4].
- R5: On an update, bit 6 (zero) becomes 1 exactly when the result bits inside the selected width are all 0. Width code 0 is 8 bits, code 1 is 16 bits, and codes 2 and 3 are 32 bits. Bits above the width are ignored.
- R6: On an update, bit 7 (sign) becomes the top result bit of the selected width.
- R7: On an update, bit 11 (overflow) becomes 1 when the signed add or subtract overflows at the selected width.
- R8: Command code 1 sets bit 10 (direction) and command code 2 clears it.
- R9: Command code 3 sets bit 9 (interrupt enable) and command code 4 clears it. irq_take_o equals irq_i while bit 9 is 1 and is 0 otherwise.
- R10: Command code 5 loads bit 8 (trap) from trap_val_i. Codes 0, 6 and 7 change no control bit.
- R11: A command leaves bits 0, 2, 4, 6, 7 and 11 unchanged. An update leaves bits 8, 9 and 10 unchanged. When an update and a command occur in the same cycle, both take effect.
- R12: Bit 1 of flags_o is always 1. Bits 3, 5 and 12 to 15 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| upd_en_i | input | 1 | Capture status flags from the current operation |
| sub_i | input | 1 | 1 for subtract, 0 for add |
| width_i | input | 2 | Operation width code: 0 is 8 bits, 1 is 16 bits, 2 and 3 are 32 bits |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| res_i | input | 32 | Result produced by the datapath |
| cmd_i | input | 3 | Control-bit command code |
| trap_val_i | input | 1 | Value loaded into the trap bit by command 5 |
| irq_i | input | 1 | Maskable interrupt request |
| flags_o | output | 16 | Packed flags word |
| irq_take_o | output | 1 | Interrupt request accepted |

## Verification
A status update and a control command can arrive on the same clock edge. The two must not interfere, because each touches a separate group of bits in the one flags word. The bench provokes this by raising upd_en_i and giving a direction-clear command on the same edge, with control bits already set and status flags already nonzero. The result is judged correct only if the new status flags appear and the direction bit clears, while the interrupt and trap bits keep their values.

// File: rtl/flags_pkg.sv
package flags_pkg;
  localparam int NUM_W  = 3;                   // 8, 16, 32
  localparam int DATA_W = 8 << (NUM_W - 1);
  localparam int WORD_W = 16;

  localparam int CF_BIT = 0;
  localparam int ON_BIT = 1;
  localparam int PF_BIT = 2;
  localparam int AF_BIT = 4;
  localparam int ZF_BIT = 6;
  localparam int SF_BIT = 7;
  localparam int TF_BIT = 8;
  localparam int IF_BIT = 9;
  localparam int DF_BIT = 10;
  localparam int OF_BIT = 11;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_DIR_SET = 3'd1,
    CMD_DIR_CLR = 3'd2,
    CMD_INT_SET = 3'd3,
    CMD_INT_CLR = 3'd4,
    CMD_TRAP_LD = 3'd5
  } cmd_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } arith_t;
endpackage

// File: rtl/flags_arith.sv
module flags_arith
  import flags_pkg::*;
(
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [1:0]        width_i,
  input  logic              sub_i,
  output arith_t            flags_o
);
  logic [NUM_W-1:0] cy_w, ov_w, sg_w, zr_w;

  for (genvar g = 0; g < NUM_W; g++) begin : g_width
    localparam int W = 8 << g;
    logic am, bm, rm;
    assign am = opa_i[W-1];
    assign bm = opb_i[W-1];
    assign rm = res_i[W-1];
    // carry out on add, borrow on subtract
    assign cy_w[g] = sub_i ? ((~am & bm) | ((~am | bm) & rm))
                           : ((am & bm) | ((am | bm) & ~rm));
    assign ov_w[g] = sub_i ? ((am ^ bm) & (rm ^ am))
                           : (~(am ^ bm) & (rm ^ am));
    assign sg_w[g] = rm;
    assign zr_w[g] = ~|res_i[W-1:0];
  end

  logic [1:0] sel;
  always_comb begin
    sel = (width_i >= 2'(NUM_W - 1)) ? 2'(NUM_W - 1) : width_i;
  end

  always_comb begin
    flags_o.cf = cy_w[sel];
    flags_o.of = ov_w[sel];
    flags_o.sf = sg_w[sel];
    flags_o.zf = zr_w[sel];
    flags_o.pf = ~^res_i[7:0];
    flags_o.af = opa_i[4] ^ opb_i[4] ^ res_i[4];
  end
endmodule

// File: rtl/flags_ctrl.sv
module flags_ctrl
  import flags_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] cmd_i,
  input  logic       trap_val_i,
  input  logic       irq_i,
  output logic       df_o,
  output logic       ie_o,
  output logic       tf_o,
  output logic       irq_take_o
);
  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  logic df_q, ie_q, tf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      df_q <= 1'b0;
      ie_q <= 1'b0;
      tf_q <= 1'b0;
    end else begin
      case (cmd)
        CMD_DIR_SET: df_q <= 1'b1;
        CMD_DIR_CLR: df_q <= 1'b0;
        CMD_INT_SET: ie_q <= 1'b1;
        CMD_INT_CLR: ie_q <= 1'b0;
        CMD_TRAP_LD: tf_q <= trap_val_i;
        default: ;
      endcase
    end
  end

  assign df_o       = df_q;
  assign ie_o       = ie_q;
  assign tf_o       = tf_q;
  assign irq_take_o = irq_i & ie_q;

  p_dir_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1) |=> df_o);
  p_dir_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd2) |=> !df_o);
  p_int_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd3) |=> ie_o);
  p_int_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd4) |=> !irq_take_o);
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd0 || cmd_i > 3'd5) |=> $stable({df_o, ie_o, tf_o}));
endmodule

// File: rtl/flags_unit.sv
module flags_unit
  import flags_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_en_i,
  input  logic              sub_i,
  input  logic [1:0]        width_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [2:0]        cmd_i,
  input  logic              trap_val_i,
  input  logic              irq_i,
  output logic [WORD_W-1:0] flags_o,
  output logic              irq_take_o
);
  arith_t arith_d, arith_q;
  logic   df, ie, tf;

  flags_arith u_arith (
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .res_i   (res_i),
    .width_i (width_i),
    .sub_i   (sub_i),
    .flags_o (arith_d)
  );

  flags_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd_i),
    .trap_val_i (trap_val_i),
    .irq_i      (irq_i),
    .df_o       (df),
    .ie_o       (ie),
    .tf_o       (tf),
    .irq_take_o (irq_take_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       arith_q <= '0;
    else if (upd_en_i) arith_q <= arith_d;
  end

  always_comb begin
    flags_o         = '0;
    flags_o[ON_BIT] = 1'b1;
    flags_o[CF_BIT] = arith_q.cf;
    flags_o[PF_BIT] = arith_q.pf;
    flags_o[AF_BIT] = arith_q.af;
    flags_o[ZF_BIT] = arith_q.zf;
    flags_o[SF_BIT] = arith_q.sf;
    flags_o[OF_BIT] = arith_q.of;
    flags_o[TF_BIT] = tf;
    flags_o[IF_BIT] = ie;
    flags_o[DF_BIT] = df;
  end

  p_arith_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> $stable({flags_o[11], flags_o[7:6], flags_o[4], flags_o[2], flags_o[0]}));
  p_ctrl_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd0) |=> $stable(flags_o[10:8]));
  p_zero_pos_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[ZF_BIT] |-> !flags_o[SF_BIT]);
  p_zero_par_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[ZF_BIT] |-> flags_o[PF_BIT]);
  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> flags_o[IF_BIT]);
endmodule

// File: tb/flags_unit_test.sv
module flags_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        upd_en_i = 1'b0, sub_i = 1'b0, trap_val_i = 1'b0, irq_i = 1'b0;
  logic [1:0]  width_i = '0;
  logic [31:0] opa_i = '0, opb_i = '0, res_i = '0;
  logic [2:0]  cmd_i = '0;
  logic [15:0] flags_o;
  logic        irq_take_o;
  int checks = 0, failures = 0;

  always #2 clk_i = ~clk_i;

  flags_unit uut (.*);

  // {opa, opb, res, width, sub, expected flags}
  localparam logic [114:0] VEC [12] = '{
    {32'h000000FF, 32'h00000001, 32'h00000000, 2'd0, 1'b0, 16'h0057},
    {32'h0000007F, 32'h00000001, 32'h00000080, 2'd0, 1'b0, 16'h0892},
    {32'h00000000, 32'h00000001, 32'h000000FF, 2'd0, 1'b1, 16'h0097},
    {32'h00000080, 32'h00000001, 32'h0000007F, 2'd0, 1'b1, 16'h0812},
    {32'h00001234, 32'h00004321, 32'h00005555, 2'd1, 1'b0, 16'h0006},
    {32'h0000FFFF, 32'h00000001, 32'h00010000, 2'd1, 1'b0, 16'h0057},
    {32'h00008000, 32'h00000001, 32'h00007FFF, 2'd1, 1'b1, 16'h0816},
    {32'h7FFFFFFF, 32'h00000001, 32'h80000000, 2'd2, 1'b0, 16'h0896},
    {32'h00000005, 32'h00000005, 32'h00000000, 2'd2, 1'b1, 16'h0046},
    {32'h00000000, 32'h00000001, 32'hFFFFFFFF, 2'd3, 1'b1, 16'h0097},
    {32'h12345610, 32'h000000F0, 32'h12345700, 2'd0, 1'b0, 16'h0047},
    {32'h00000000, 32'h00000080, 32'h00000080, 2'd1, 1'b0, 16'h0002}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, sample at next negedge
  task automatic step(input logic upd, input logic [114:0] v, input logic [2:0] cmd, input logic tv);
    upd_en_i = upd;
    opa_i = v[114:83]; opb_i = v[82:51]; res_i = v[50:19];
    width_i = v[18:17]; sub_i = v[16];
    cmd_i = cmd; trap_val_i = tv;
    @(negedge clk_i);
    upd_en_i = 1'b0; cmd_i = 3'd0;
    opa_i = 32'hA5A5A5A5; opb_i = 32'h5A5A5A5A; res_i = 32'h0F0F0F0F;
  endtask

  initial begin
    #1;
    chk("R1 reset word", flags_o, 16'h0002);
    chk("R1 reset irq", {15'd0, irq_take_o}, 16'h0000);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R3 R4 R5 R6 R7 R12 vector walk
    for (int i = 0; i < 12; i++) begin
      step(1'b1, VEC[i], 3'd0, 1'b0);
      chk($sformatf("R2-flags vector %0d (R3 R4 R5 R6 R7 R12)", i), flags_o, VEC[i][15:0]);
    end

    step(1'b1, VEC[2], 3'd0, 1'b0);
    chk("R2 borrow reload", flags_o, 16'h0097);
    irq_i = 1'b1;
    #0.1;
    chk("R9 gate closed", {15'd0, irq_take_o}, 16'h0000);
    step(1'b0, VEC[0], 3'd1, 1'b0);
    chk("R8 dir set, R11 arith kept", flags_o, 16'h0497);
    step(1'b0, VEC[0], 3'd3, 1'b0);
    chk("R9 int set", flags_o, 16'h0697);
    chk("R9 gate open", {15'd0, irq_take_o}, 16'h0001);
    irq_i = 1'b0;
    #0.1;
    chk("R9 no request", {15'd0, irq_take_o}, 16'h0000);
    irq_i = 1'b1;
    step(1'b0, VEC[0], 3'd5, 1'b1);
    chk("R10 trap load 1", flags_o, 16'h0797);
    step(1'b0, VEC[0], 3'd6, 1'b0);
    chk("R10 code 6 no effect", flags_o, 16'h0797);
    step(1'b0, VEC[0], 3'd7, 1'b0);
    chk("R10 code 7 no effect", flags_o, 16'h0797);
    step(1'b1, VEC[8], 3'd2, 1'b0);
    chk("R11 update plus dir clear", flags_o, 16'h0346);
    step(1'b0, VEC[0], 3'd4, 1'b0);
    chk("R9 int clr", flags_o, 16'h0146);
    chk("R9 gate closed again", {15'd0, irq_take_o}, 16'h0000);
    step(1'b0, VEC[0], 3'd5, 1'b0);
    chk("R10 trap load 0", flags_o, 16'h0046);
    step(1'b0, VEC[0], 3'd2, 1'b0);
    chk("R8 clear when clear", flags_o, 16'h0046);
    step(1'b0, VEC[0], 3'd1, 1'b0);
    step(1'b0, VEC[0], 3'd3, 1'b0);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1 async reset word", flags_o, 16'h0002);
    chk("R1 async reset irq", {15'd0, irq_take_o}, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    checks++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule